// File: doc/BRIEF.md
# Serial Port Bit-Rate Strobe Selector

This block makes the bit-period strobes for a serial port that has four operating modes. The transmit side and the receive side each get their own strobe. Each strobe is made by counting ticks from one of three sources: the machine-cycle tick, the overflow of a general timer (timer A), or the overflow of a baud timer (timer B). The block fires one strobe each time the count reaches the divide ratio. The serial mode sets which source is counted and what the ratio is. A speed-doubling input also changes the ratio, and in the timer-driven modes, one clock-select bit per direction picks the timer.

A direction counts only while its activity flag is high. When the flag drops, that direction's count returns to zero, so the next frame starts from a fresh count. Each direction keeps its own accumulator. If the ratio changes while a count is in progress and the accumulator is already at or above the new ratio, the next tick fires a strobe and the amount past the ratio is kept. All pins are plain level or pulse signals. There is no data stream, so there is no valid/ready handshake and no back-pressure. The strobes are registered, single-clock pulses that the shift logic next to this block consumes directly.

Top module: `uart_bitrate_sel`

## Requirements
- R1: With `ser_mode` = 0, each direction counts `mc_tick` and fires one strobe every 12 ticks; `dbl_speed` and the clock-select bits have no effect in this mode.
- R2: With `ser_mode` = 2, each direction counts `mc_tick` with a ratio of 16 when `dbl_speed` = 1 and 32 when `dbl_speed` = 0.
- R3: With `ser_mode` = 1 or 3, the transmit side counts `t2_ovf` when `tx_clk_sel` = 1 and `t1_ovf` when it is 0; ticks on the unselected sources are ignored.
- R4: With `ser_mode` = 1 or 3, the receive side chooses between `t2_ovf` (`rx_clk_sel` = 1) and `t1_ovf` (`rx_clk_sel` = 0) independently of the transmit side.
- R5: With `ser_mode` = 1 or 3, the ratio is 16 when `dbl_speed` = 1 and 32 when it is 0.
- R6: The transmit count advances only while `tx_active` = 1, and the receive count only while `rx_active` = 1; an inactive direction produces no strobe.
- R7: A direction that is inactive for at least one clock has its count cleared to zero.
- R8: When a tick brings the count to or past the ratio, one strobe fires and the count becomes the count minus the ratio, so the excess is kept (for example, 20 ticks at ratio 32 followed by a switch to ratio 16 fires on the very next tick and then again 11 ticks later).
- R9: A strobe is high for exactly one clock, on the clock after the rising edge that takes the counting tick; there is at most one strobe per direction per clock, and the reset value of both strobes is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle tick, one clock wide |
| t1_ovf | input | 1 | Timer A overflow pulse |
| t2_ovf | input | 1 | Timer B baud overflow pulse |
| ser_mode | input | 2 | Serial mode 0..3 |
| dbl_speed | input | 1 | Halves the ratio in modes 1, 2 and 3 |
| tx_clk_sel | input | 1 | Transmit source select (1 = timer B) |
| rx_clk_sel | input | 1 | Receive source select (1 = timer B) |
| tx_active | input | 1 | Transmit frame in progress |
| rx_active | input | 1 | Receive frame in progress |
| tx_bit_stb | output | 1 | Transmit bit-period strobe |
| rx_bit_stb | output | 1 | Receive bit-period strobe |

## Verification
The bench drives continuous ticks on one source at a time and checks strobe counts at exact ratio multiples and one tick short of them. This separates the ratios 12, 16 and 32 and shows which source is counted. In the timer modes it pulses timer A alone, then timer B alone, with opposite select bits on the two directions. This shows the directions choose their sources independently and that the unselected source and `mc_tick` are ignored. Further patterns activate only one direction, interrupt a partial count with an idle clock, and switch the ratio from 32 to 16 after a partial count. These separate gated counting from free running, clearing on idle from holding the count, and keeping the excess from restarting at zero.

// File: rtl/baud_sel_pkg.sv
package baud_sel_pkg;
  typedef enum logic [1:0] {
    SM_SHIFT = 2'd0,
    SM_VAR_A = 2'd1,
    SM_FIXED = 2'd2,
    SM_VAR_B = 2'd3
  } ser_mode_e;
endpackage

// File: rtl/bit_src_sel.sv
module bit_src_sel
  import baud_sel_pkg::*;
#(
  parameter int DIV_SHIFT = 12,
  parameter int DIV_FAST  = 16,
  parameter int DIV_SLOW  = 32,
  parameter int AW        = 6
) (
  input  logic [1:0]    ser_mode,
  input  logic          dbl_speed,
  input  logic          clk_sel,
  input  logic          mc_tick,
  input  logic          t1_ovf,
  input  logic          t2_ovf,
  output logic          tick,
  output logic [AW-1:0] ratio
);
  localparam logic [AW-1:0] R_SHIFT = AW'(DIV_SHIFT);
  localparam logic [AW-1:0] R_FAST  = AW'(DIV_FAST);
  localparam logic [AW-1:0] R_SLOW  = AW'(DIV_SLOW);

  always_comb begin
    unique case (ser_mode_e'(ser_mode))
      SM_SHIFT: begin
        tick  = mc_tick;
        ratio = R_SHIFT;
      end
      SM_FIXED: begin
        tick  = mc_tick;
        ratio = dbl_speed ? R_FAST : R_SLOW;
      end
      default: begin
        tick  = clk_sel ? t2_ovf : t1_ovf;
        ratio = dbl_speed ? R_FAST : R_SLOW;
      end
    endcase
  end
endmodule

// File: rtl/bit_accum.sv
module bit_accum #(
  parameter int AW    = 6,
  parameter int MAX_R = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          tick,
  input  logic [AW-1:0] ratio,
  output logic          stb
);
  logic [AW-1:0] acc;
  logic [AW:0]   sum;

  assign sum = {1'b0, acc} + {{AW{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      stb <= 1'b0;
    end else if (!active) begin
      acc <= '0;
      stb <= 1'b0;
    end else if (tick) begin
      if (sum >= {1'b0, ratio}) begin
        acc <= AW'(sum - {1'b0, ratio});
        stb <= 1'b1;
      end else begin
        acc <= sum[AW-1:0];
        stb <= 1'b0;
      end
    end else begin
      stb <= 1'b0;
    end
  end

  // R6: an idle direction never strobes
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !stb);
  // R7: idle clears the count
  a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> acc == '0);
  // R9: strobes are single-clock pulses
  a_r9_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
  // R9: a strobe follows a counted tick
  a_r9_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb) |-> $past(tick && active));
  // R8: the remainder stays below the largest ratio
  a_r8_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, acc} < (AW+1)'(MAX_R));
endmodule

// File: rtl/uart_bitrate_sel.sv
module uart_bitrate_sel #(
  parameter int DIV_SHIFT = 12,
  parameter int DIV_FAST  = 16,
  parameter int DIV_SLOW  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mc_tick,
  input  logic       t1_ovf,
  input  logic       t2_ovf,
  input  logic [1:0] ser_mode,
  input  logic       dbl_speed,
  input  logic       tx_clk_sel,
  input  logic       rx_clk_sel,
  input  logic       tx_active,
  input  logic       rx_active,
  output logic       tx_bit_stb,
  output logic       rx_bit_stb
);
  localparam int MAX_R = (DIV_SLOW > DIV_SHIFT) ?
                         ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST) :
                         ((DIV_SHIFT > DIV_FAST) ? DIV_SHIFT : DIV_FAST);
  localparam int AW    = $clog2(MAX_R + 1);
  localparam int NDIR  = 2;

  logic [NDIR-1:0] dir_sel;
  logic [NDIR-1:0] dir_act;
  logic [NDIR-1:0] dir_stb;

  assign dir_sel = {rx_clk_sel, tx_clk_sel};
  assign dir_act = {rx_active, tx_active};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic          tick;
    logic [AW-1:0] ratio;

    bit_src_sel #(
      .DIV_SHIFT(DIV_SHIFT), .DIV_FAST(DIV_FAST),
      .DIV_SLOW(DIV_SLOW), .AW(AW)
    ) u_sel (
      .ser_mode (ser_mode),
      .dbl_speed(dbl_speed),
      .clk_sel  (dir_sel[d]),
      .mc_tick  (mc_tick),
      .t1_ovf   (t1_ovf),
      .t2_ovf   (t2_ovf),
      .tick     (tick),
      .ratio    (ratio)
    );

    bit_accum #(.AW(AW), .MAX_R(MAX_R)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .active(dir_act[d]),
      .tick  (tick),
      .ratio (ratio),
      .stb   (dir_stb[d])
    );
  end

  assign tx_bit_stb = dir_stb[0];
  assign rx_bit_stb = dir_stb[1];

  // R1: in shift mode only the machine tick can cause a strobe
  a_r1_shift_src: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ser_mode) == 2'd0 && !$past(mc_tick)) |-> !tx_bit_stb && !rx_bit_stb);
endmodule

// File: tb/uart_bitrate_sel_tb.sv
module uart_bitrate_sel_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_tick = 0, t1_ovf = 0, t2_ovf = 0;
  logic [1:0] ser_mode = 2'd0;
  logic dbl_speed = 0, tx_clk_sel = 0, rx_clk_sel = 0;
  logic tx_active = 0, rx_active = 0;
  logic tx_bit_stb, rx_bit_stb;

  int n_checks = 0;
  int n_fail = 0;
  int tx_cnt, rx_cnt;
  bit dbl_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_bitrate_sel u_dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .t1_ovf(t1_ovf),
    .t2_ovf(t2_ovf), .ser_mode(ser_mode), .dbl_speed(dbl_speed),
    .tx_clk_sel(tx_clk_sel), .rx_clk_sel(rx_clk_sel),
    .tx_active(tx_active), .rx_active(rx_active),
    .tx_bit_stb(tx_bit_stb), .rx_bit_stb(rx_bit_stb)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive n clocks of ticks on the chosen sources, counting strobes.
  task automatic run(int n, bit m, bit a, bit b);
    bit ptx = 0, prx = 0;
    tx_cnt = 0; rx_cnt = 0;
    for (int i = 0; i < n; i++) begin
      mc_tick = m; t1_ovf = a; t2_ovf = b;
      @(negedge clk);
      if (tx_bit_stb) tx_cnt++;
      if (rx_bit_stb) rx_cnt++;
      if ((tx_bit_stb && ptx) || (rx_bit_stb && prx)) dbl_seen = 1;
      ptx = tx_bit_stb; prx = rx_bit_stb;
    end
    mc_tick = 0; t1_ovf = 0; t2_ovf = 0;
    @(negedge clk);
    if (tx_bit_stb) tx_cnt++;
    if (rx_bit_stb) rx_cnt++;
  endtask

  task automatic go_idle(bit tx_on, bit rx_on);
    tx_active = 0; rx_active = 0;
    @(negedge clk);
    tx_active = tx_on; rx_active = rx_on;
  endtask

  task automatic t_reset;
    check("R9 reset tx", int'(tx_bit_stb), 0);
    check("R9 reset rx", int'(rx_bit_stb), 0);
    rst_n = 1;
    @(negedge clk);
    run(5, 0, 0, 0);
    check("R9 quiet tx", tx_cnt, 0);
  endtask

  task automatic t_shift_mode;
    ser_mode = 2'd0; dbl_speed = 0;
    go_idle(1, 1);
    run(11, 1, 1, 1);
    check("R1 11 ticks tx", tx_cnt, 0);
    run(1, 1, 0, 0);
    check("R1 12th tick tx", tx_cnt, 1);
    check("R1 12th tick rx", rx_cnt, 1);
    dbl_speed = 1; tx_clk_sel = 1;
    go_idle(1, 1);
    run(24, 1, 0, 0);
    check("R1 dbl ignored tx", tx_cnt, 2);
    check("R1 dbl ignored rx", rx_cnt, 2);
    dbl_speed = 0; tx_clk_sel = 0;
  endtask

  task automatic t_fixed_mode;
    ser_mode = 2'd2; dbl_speed = 0;
    go_idle(1, 1);
    run(31, 1, 1, 1);
    check("R2 slow 31 tx", tx_cnt, 0);
    run(33, 1, 0, 0);
    check("R2 slow 64 tx", tx_cnt, 2);
    dbl_speed = 1;
    go_idle(1, 1);
    run(32, 1, 0, 0);
    check("R2 fast 32 rx", rx_cnt, 2);
  endtask

  task automatic t_timer_modes;
    ser_mode = 2'd1; dbl_speed = 0; tx_clk_sel = 1; rx_clk_sel = 0;
    go_idle(1, 1);
    run(32, 1, 0, 1);
    check("R3 tx on timer B", tx_cnt, 1);
    check("R4 rx ignores timer B", rx_cnt, 0);
    go_idle(1, 1);
    run(32, 1, 1, 0);
    check("R3 tx ignores timer A", tx_cnt, 0);
    check("R4 rx on timer A", rx_cnt, 1);
    ser_mode = 2'd3; dbl_speed = 1; tx_clk_sel = 0; rx_clk_sel = 1;
    go_idle(1, 1);
    run(16, 0, 1, 0);
    check("R5 fast tx timer A", tx_cnt, 1);
    check("R4 rx idle on A", rx_cnt, 0);
    go_idle(1, 1);
    run(15, 0, 0, 1);
    check("R5 fast 15 rx", rx_cnt, 0);
    run(1, 0, 0, 1);
    check("R5 fast 16 rx", rx_cnt, 1);
    tx_clk_sel = 0; rx_clk_sel = 0;
  endtask

  task automatic t_gating;
    ser_mode = 2'd2; dbl_speed = 1;
    go_idle(0, 1);
    run(16, 1, 0, 0);
    check("R6 tx inactive", tx_cnt, 0);
    check("R6 rx active", rx_cnt, 1);
    go_idle(1, 1);
    run(10, 1, 0, 0);
    go_idle(1, 1);
    run(10, 1, 0, 0);
    check("R7 cleared by idle", tx_cnt, 0);
    run(6, 1, 0, 0);
    check("R7 fresh count", tx_cnt, 1);
  endtask

  task automatic t_excess;
    ser_mode = 2'd2; dbl_speed = 0;
    go_idle(1, 1);
    run(20, 1, 0, 0);
    check("R8 no early strobe", tx_cnt, 0);
    dbl_speed = 1;
    run(1, 1, 0, 0);
    check("R8 immediate strobe", tx_cnt, 1);
    run(10, 1, 0, 0);
    check("R8 excess 15", tx_cnt, 0);
    run(1, 1, 0, 0);
    check("R8 excess kept", tx_cnt, 1);
    check("R9 no back-to-back", int'(dbl_seen), 0);
  endtask

  initial begin
    dbl_seen = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_shift_mode();
    t_fixed_mode();
    t_timer_modes();
    t_gating();
    t_excess();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule